// File: doc/BRIEF.md
# Connection Memory Block Initializer

This block writes a single control word into every location of a switch's connection memory. Software prepares it in three steps. It places a 5-bit pattern in the pattern field of the interface mode register (bits 5 to 9 of that register, presented here as the `pattern` input). It raises the block-mode bit of the control register. Then it writes a one to the block enable bit, which is held inside this block. A small sequencer then walks the whole address range. It issues one memory write per cycle, but only in cycles that the output read path leaves free. Each word carries the pattern in its top five bits and zeros below. When the last location is written, the sequencer clears the enable bit by itself, and software can poll that bit to see that the fill is complete.

Normal processor writes to the connection memory share the same write port. While a fill is running, the block holds those writes off with a stall signal. When the block is idle, processor writes pass straight through to the port in the same cycle. If software drops the block-mode bit during a fill, the fill stops at once and the enable bit is cleared.

The sequencer has three states:
- `ST_IDLE`: processor writes pass through, and the address counter is held at zero.
- `ST_FILL`: one location is written per free slot.
- `ST_DONE`: a single cycle that closes the fill and clears the enable bit.

Transitions:
- `ST_IDLE` to `ST_FILL` when the enable bit and the mode bit are both high. The pattern is latched on this edge.
- `ST_FILL` to `ST_DONE` on the write to the last address.
- `ST_FILL` or `ST_DONE` to `ST_IDLE` when the mode bit is low (abort).
- `ST_DONE` to `ST_IDLE` unconditionally.

Top module: `cm_block_init`

## Requirements
- R1: After reset, `en_bit` and `fill_busy` are 0, and `mem_we` is 0 while `cpu_req` is 0.
- R2: The pattern is captured on the cycle the fill starts. Changes on `pattern` during a fill have no effect on the words written.
- R3: Every fill word has the captured pattern in bits [15:11] and zero in bits [10:0].
- R4: A fill writes each address from 0 to DEPTH-1 exactly once, in ascending order.
- R5: When the last location has been written, the hardware clears `en_bit`. With `slot_free` held high, `en_bit` reads 1 for exactly DEPTH+2 cycles, counted from the cycle after the enable write.
- R6: While `fill_busy` is 1, a processor write request is stalled, and its address and data do not reach the memory port.
- R7: While idle, `cpu_req` drives `mem_we`, and `cpu_addr`/`cpu_data` appear on `mem_addr`/`mem_wdata` in the same cycle.
- R8: If `blk_mode` is low during a fill, then in the next cycle `en_bit` and `fill_busy` are 0, and no further fill writes occur.
- R9: A write of 1 to the enable bit while `blk_mode` is low has no effect: `en_bit` stays 0 and no fill starts.
- R10: In a cycle with `slot_free` low, no fill write takes place. The fill resumes at the address where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_mode | input | 1 | Block-mode bit from the control register |
| pattern | input | PAT_W | Pattern field from the interface mode register |
| en_wr | input | 1 | Processor write strobe for the enable bit |
| en_wdata | input | 1 | Value written to the enable bit |
| slot_free | input | 1 | Cycle not used by the output read path |
| cpu_req | input | 1 | Processor connection-memory write request |
| cpu_addr | input | ADDR_W | Processor write address |
| cpu_data | input | DATA_W | Processor write data |
| en_bit | output | 1 | Current enable bit, cleared by hardware |
| fill_busy | output | 1 | Fill in progress; stalls processor writes |
| mem_we | output | 1 | Connection memory write enable |
| mem_addr | output | ADDR_W | Connection memory write address |
| mem_wdata | output | DATA_W | Connection memory write data |

## Verification
A wrong sequencer state shows up at once as `en_bit` or `fill_busy` holding the wrong level. It also shows up as the fill count differing from DEPTH by the end of the fill, within DEPTH+2 cycles when every slot is free. A fault in the address counter leaves a location holding its previous contents, or writes out of order, and this is visible as soon as the memory image is compared after `en_bit` falls. A fault in the pattern register or the data mux shows on the first word written, one cycle after the fill starts.

// File: rtl/cmbi_pkg.sv
package cmbi_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_DONE = 2'd2
    } cmbi_state_e;
endpackage

// File: rtl/cmbi_addr_ctr.sv
module cmbi_addr_ctr #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr,
    output logic              at_last
);
    localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n || clr) addr <= '0;
        else if (inc)      addr <= addr + 1'b1;
    end

    assign at_last = (addr == LAST);

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |=> (addr == $past(addr) + 1'b1));
endmodule

// File: rtl/cmbi_seq.sv
module cmbi_seq
    import cmbi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic blk_mode,
    input  logic en_wr,
    input  logic en_wdata,
    input  logic slot_free,
    input  logic at_last,
    output logic en_bit,
    output logic busy,
    output logic fill_we,
    output logic ctr_clr,
    output logic pat_load
);
    cmbi_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (en_bit && blk_mode) state_nx = ST_FILL;
            ST_FILL: begin
                if (!blk_mode)                  state_nx = ST_IDLE;
                else if (slot_free && at_last)  state_nx = ST_DONE;
            end
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !blk_mode)          en_bit <= 1'b0;
        else if (state == ST_DONE)        en_bit <= 1'b0;
        else if (en_wr && state == ST_IDLE) en_bit <= en_wdata;
    end

    always_comb begin
        busy     = (state != ST_IDLE);
        fill_we  = (state == ST_FILL) && blk_mode && slot_free;
        ctr_clr  = (state == ST_IDLE);
        pat_load = (state == ST_IDLE) && en_bit && blk_mode;
    end

    // R5
    done_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |=> (!en_bit && state == ST_IDLE));
    // R8
    abort_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !blk_mode) |=> (!busy && !en_bit));
    // R9
    mode_low_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !blk_mode) |=> (state == ST_IDLE));
endmodule

// File: rtl/cmbi_wr_path.sv
module cmbi_wr_path #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 16,
    parameter int PAT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pat_load,
    input  logic [PAT_W-1:0]  pattern,
    input  logic              busy,
    input  logic              fill_we,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    localparam int LOW_W = DATA_W - PAT_W;

    logic [PAT_W-1:0]  pat_q;
    logic [DATA_W-1:0] fill_word;

    always_ff @(posedge clk) begin
        if (!rst_n)        pat_q <= '0;
        else if (pat_load) pat_q <= pattern;
    end

    assign fill_word = {pat_q, {LOW_W{1'b0}}};

    always_comb begin
        if (busy) begin
            mem_we    = fill_we;
            mem_addr  = fill_addr;
            mem_wdata = fill_word;
        end else begin
            mem_we    = cpu_req;
            mem_addr  = cpu_addr;
            mem_wdata = cpu_data;
        end
    end

    // R3
    fill_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_we) |-> (mem_wdata[LOW_W-1:0] == '0));
    // R2
    pat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(pat_q));
    // R6
    stall_no_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fill_we) |-> !mem_we);
endmodule

// File: rtl/cm_block_init.sv
module cm_block_init #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 16,
    parameter int PAT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blk_mode,
    input  logic [PAT_W-1:0]  pattern,
    input  logic              en_wr,
    input  logic              en_wdata,
    input  logic              slot_free,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_data,
    output logic              en_bit,
    output logic              fill_busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    logic              fill_we, ctr_clr, pat_load, at_last;
    logic [ADDR_W-1:0] fill_addr;

    cmbi_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .blk_mode (blk_mode),
        .en_wr    (en_wr),
        .en_wdata (en_wdata),
        .slot_free(slot_free),
        .at_last  (at_last),
        .en_bit   (en_bit),
        .busy     (fill_busy),
        .fill_we  (fill_we),
        .ctr_clr  (ctr_clr),
        .pat_load (pat_load)
    );

    cmbi_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (ctr_clr),
        .inc    (fill_we),
        .addr   (fill_addr),
        .at_last(at_last)
    );

    cmbi_wr_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAT_W(PAT_W)) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .pat_load (pat_load),
        .pattern  (pattern),
        .busy     (fill_busy),
        .fill_we  (fill_we),
        .fill_addr(fill_addr),
        .cpu_req  (cpu_req),
        .cpu_addr (cpu_addr),
        .cpu_data (cpu_data),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata)
    );
endmodule

// File: tb/cm_block_init_test.sv
`timescale 1ns/1ps
module cm_block_init_test;
    localparam int AW = 4;
    localparam int DW = 16;
    localparam int PW = 5;
    localparam int DEPTH = 1 << AW;
    localparam logic [DW-1:0] PRESET = 16'h07A5;

    // {pattern, slot gap}
    localparam logic [7:0] VECS [0:4] = '{
        {5'h1F, 3'd1}, {5'h00, 3'd1}, {5'h15, 3'd2}, {5'h0A, 3'd3}, {5'h11, 3'd1}
    };

    logic clk = 0, rst_n = 0, blk_mode = 0, en_wr = 0, en_wdata = 0, slot_free = 0;
    logic [PW-1:0] pattern = '0;
    logic cpu_req = 0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_data = '0;
    logic en_bit, fill_busy, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;

    int compared = 0, mismatched = 0;
    int gap = 1, phase = 0;
    int fill_writes = 0, order_err = 0, next_addr = 0;
    logic [DW-1:0] model [DEPTH];

    always #4 clk = ~clk;

    cm_block_init #(.ADDR_W(AW), .DATA_W(DW), .PAT_W(PW)) uut (
        .clk(clk), .rst_n(rst_n), .blk_mode(blk_mode), .pattern(pattern),
        .en_wr(en_wr), .en_wdata(en_wdata), .slot_free(slot_free),
        .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .en_bit(en_bit), .fill_busy(fill_busy), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata));

    always @(negedge clk) begin
        if (gap == 0) slot_free = 1'b0;
        else begin
            slot_free = (phase == 0);
            phase = (phase + 1) % gap;
        end
    end

    always @(posedge clk) begin
        if (mem_we) begin
            model[mem_addr] <= mem_wdata;
            if (fill_busy) begin
                if (int'(mem_addr) != next_addr) order_err++;
                next_addr++;
                fill_writes++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic preset_mem();
        for (int i = 0; i < DEPTH; i++) model[i] = PRESET;
        fill_writes = 0; next_addr = 0; order_err = 0;
    endtask

    task automatic write_en();
        @(negedge clk); en_wr = 1; en_wdata = 1;
        @(negedge clk); en_wr = 0; en_wdata = 0;
    endtask

    task automatic wait_clear(output int cnt);
        cnt = 0;
        while (en_bit && cnt < 1000) begin cnt++; @(negedge clk); end
    endtask

    task automatic check_image(input logic [PW-1:0] p, input string req);
        int bad = 0, first = 0;
        for (int i = 0; i < DEPTH; i++)
            if (model[i] !== {p, 11'b0}) begin
                if (bad == 0) first = i;
                bad++;
            end
        check(bad == 0, req, int'(model[first]), int'({p, 11'b0}));
    endtask

    initial begin
        int cnt;
        logic [PW-1:0] p;
        int g;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(en_bit == 0, "R1 en_bit", en_bit, 0);
        check(fill_busy == 0, "R1 fill_busy", fill_busy, 0);
        check(mem_we == 0, "R1 mem_we", mem_we, 0);
        rst_n = 1;
        blk_mode = 1;
        @(negedge clk);

        // table-driven fills: R3, R4, R5, R10
        for (int v = 0; v < 5; v++) begin
            p = VECS[v][7:3];
            g = int'(VECS[v][2:0]);
            preset_mem();
            pattern = p; gap = g; phase = 0;
            write_en();
            wait_clear(cnt);
            check_image(p, "R3 fill word");
            check(fill_writes == DEPTH, "R4 write count", fill_writes, DEPTH);
            check(order_err == 0, "R4 ascending order", order_err, 0);
            if (g == 1) check(cnt == DEPTH + 2, "R5 enable duration", cnt, DEPTH + 2);
            else check(cnt <= DEPTH * g + 2 + g && cnt > DEPTH, "R10 gapped duration", cnt, DEPTH * g);
            check(en_bit == 0 && fill_busy == 0, "R5 enable cleared", en_bit, 0);
        end

        // R7 idle pass-through
        gap = 1;
        @(negedge clk); cpu_req = 1; cpu_addr = 4'd5; cpu_data = 16'h1234;
        #1;
        check(mem_we == 1 && mem_addr == 4'd5 && mem_wdata == 16'h1234, "R7 passthrough", mem_wdata, 16'h1234);
        @(negedge clk); cpu_req = 0;
        check(model[5] == 16'h1234, "R7 written", model[5], 16'h1234);

        // R6 stall during fill, R2 pattern change ignored
        preset_mem();
        pattern = 5'h0C;
        write_en();
        repeat (3) @(negedge clk);
        pattern = 5'h13;
        cpu_req = 1; cpu_addr = 4'd12; cpu_data = 16'hFFFF;
        #1;
        check(fill_busy == 1, "R6 stall", fill_busy, 1);
        check(mem_wdata == {5'h0C, 11'b0}, "R6 cpu data blocked", mem_wdata, {5'h0C, 11'b0});
        wait_clear(cnt);
        cpu_req = 0;
        check_image(5'h0C, "R2 pattern held");
        @(negedge clk);

        // R10 no free slots stalls the fill
        preset_mem();
        gap = 0; pattern = 5'h03;
        write_en();
        repeat (8) @(negedge clk);
        check(fill_writes == 0, "R10 no write without slot", fill_writes, 0);
        check(en_bit == 1 && fill_busy == 1, "R10 fill pending", en_bit, 1);
        gap = 1; phase = 0;
        wait_clear(cnt);
        check_image(5'h03, "R10 resumed fill");

        // R8 abort
        preset_mem();
        pattern = 5'h1A;
        write_en();
        repeat (4) @(negedge clk);
        blk_mode = 0;
        @(negedge clk);
        check(en_bit == 0 && fill_busy == 0, "R8 abort clears", en_bit, 0);
        cnt = fill_writes;
        repeat (4) @(negedge clk);
        check(fill_writes == cnt && cnt < DEPTH, "R8 no writes after abort", fill_writes, cnt);
        check(model[DEPTH-1] == PRESET, "R8 last untouched", model[DEPTH-1], PRESET);

        // R9 enable write while mode low
        write_en();
        check(en_bit == 0, "R9 enable ignored", en_bit, 0);
        repeat (2) @(negedge clk);
        check(fill_busy == 0, "R9 no fill", fill_busy, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(8 * 150000);
        mismatched++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule